// File: doc/BRIEF.md
# Column Hit Time-Stamp Strobe Gate

At the foot of every column of a binary pixel readout matrix, the column's wired hit line (fast-OR) is asynchronous to everything else. This block brings each column's hit line into the 40 MHz bunch-crossing clock domain and turns every new hit into a single one-bit time stamp. Those time stamps move along a per-column history register whose depth matches the trigger latency plus the delay from a hit to its fast-OR. When a trigger strobe arrives, the bit leaving the end of that column's history decides whether the strobe is passed to the column's pixels. A column with no hit in the selected bunch crossing does not get the strobe, so a wide strobe can be used and timing ambiguities stay rare.

A direct mode sends the strobe to every column without this gating. The block also merges the synchronised column hit lines into one chip-wide OR. That OR goes off chip through an output that can be switched off, and it can also stand in for the external strobe so that the chip makes its own strobe.

Top module: `col_stamp_gate`

## Requirements
- R1: After reset every history register is empty and the synchroniser flops are zero, so with gated mode on, col_strobe_o is all zero whatever strobe_i is, and chip_or_o is 0.
- R2: A low-to-high change on fastor_i[c] that is first sampled at rising clock edge k sets the history tap of column c for exactly one cycle, the one that follows edge k+DEPTH+1 (DEPTH defaults to 16).
- R3: A hit line held high for many cycles produces only one time stamp. A new stamp needs the line to go low for at least one sampled edge and then rise again.
- R4: A stamp is written only if stamp_en_i is high at the edge where it enters the history, which is edge k+2 for a rise sampled at edge k. Otherwise the hit leaves no trace.
- R5: With gated_mode_i=1, col_strobe_o[c] = selected strobe AND the history tap of column c.
- R6: With gated_mode_i=0, every bit of col_strobe_o equals the selected strobe.
- R7: chip_or_o is the OR over all columns of the hit lines as sampled one edge earlier. A line sampled high at edge n shows up after edge n+1.
- R8: With or_out_en_i=0, chip_or_o is 0.
- R9: With self_strobe_i=1, the selected strobe is the internal chip-wide OR of R7, taken before the R8 enable, and strobe_i is ignored. With self_strobe_i=0 it is strobe_i.
- R10: Columns are independent: a hit on one column never sets the tap of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stamp_en_i | input | 1 | Allows time stamps to be written |
| gated_mode_i | input | 1 | 1: strobe gated per column; 0: direct |
| self_strobe_i | input | 1 | 1: strobe taken from internal chip-wide OR |
| or_out_en_i | input | 1 | Enables the off-chip OR output |
| fastor_i | input | NCOL | Asynchronous column hit lines |
| strobe_i | input | 1 | External trigger strobe |
| col_strobe_o | output | NCOL | Strobe delivered to each column |
| chip_or_o | output | 1 | Chip-wide OR of the column hit lines |

## Verification
The hardest case to reach is a hit whose stamp arrives at the end of the history at the same moment a strobe is present. That needs a rise placed exactly DEPTH+1 edges before the strobe, with stamp_en_i high at the right edge in between. The bench keeps its own time-indexed record of every hit line and enable value it drove. From that record it predicts every tap, and it drives random strobes, modes and hit patterns for many latency windows so that such alignments happen often. Directed phases add held-high lines, single-cycle toggling, stamping switched off in the middle of a window, and a hit on a lone column.

// File: rtl/col_stamp_pkg.sv
package col_stamp_pkg;
  parameter int unsigned DEF_NCOL  = 16;
  parameter int unsigned DEF_DEPTH = 16;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/fastor_sync.sv
module fastor_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_q & ~prev_q;

  // R3: a level held high stamps once
  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hit_history.sv
module hit_history #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_in_i,
  output logic tap_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= shift_in_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DEPTH-2:0], shift_in_i};
      end
    end
  endgenerate

  assign tap_o = sr_q[DEPTH-1];

  a_r2_stamp_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_in_i |=> sr_q[0]);
  a_r4_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_in_i |=> !sr_q[0]);

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_age
      // R2: a stamp advances one stage per clock
      a_r2_stamp_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_q[i] |-> $past(sr_q[i-1]));
    end
  endgenerate
endmodule

// File: rtl/col_stamp_gate.sv
module col_stamp_gate
  import col_stamp_pkg::*;
#(
  parameter int unsigned NCOL  = DEF_NCOL,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stamp_en_i,
  input  logic            gated_mode_i,
  input  logic            self_strobe_i,
  input  logic            or_out_en_i,
  input  logic [NCOL-1:0] fastor_i,
  input  logic            strobe_i,
  output logic [NCOL-1:0] col_strobe_o,
  output logic            chip_or_o
);
  logic [NCOL-1:0] lvl, rise, shift_in, tap;
  logic            any_hit, strobe_sel;

  generate
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      fastor_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (fastor_i[c]),
        .level_o (lvl[c]),
        .rise_o  (rise[c])
      );
      assign shift_in[c] = rise[c] & stamp_en_i;
      hit_history #(.DEPTH(DEPTH)) u_hist (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_in_i (shift_in[c]),
        .tap_o      (tap[c])
      );
    end
  endgenerate

  assign any_hit    = |lvl;
  assign strobe_sel = self_strobe_i ? any_hit : strobe_i;

  always_comb begin
    if (gated_mode_i) col_strobe_o = {NCOL{strobe_sel}} & tap;
    else              col_strobe_o = {NCOL{strobe_sel}};
  end

  assign chip_or_o = or_out_en_i & any_hit;

  a_r8_or_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !or_out_en_i |-> !chip_or_o);
  a_r6_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gated_mode_i && !self_strobe_i) |-> (col_strobe_o == {NCOL{strobe_i}}));
  a_r5_no_strobe_without_stamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_mode_i |-> ((col_strobe_o & ~tap) == '0));
  a_r10_rise_per_column: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise & ~lvl) == '0);
endmodule

// File: tb/tb_col_stamp_gate.sv
`timescale 1ns/1ps
module tb_col_stamp_gate;
  localparam int NCOL  = 16;
  localparam int DEPTH = 16;
  localparam int HLEN  = 64;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            stamp_en = 1'b0, gated = 1'b0, self_s = 1'b0, or_en = 1'b0;
  logic [NCOL-1:0] fastor = '0;
  logic            strobe = 1'b0;
  logic [NCOL-1:0] col_strobe;
  logic            chip_or;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  logic [NCOL-1:0] hin [HLEN];
  logic            hen [HLEN];

  always #2 clk = ~clk;

  col_stamp_gate #(.NCOL(NCOL), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stamp_en_i(stamp_en), .gated_mode_i(gated),
    .self_strobe_i(self_s), .or_out_en_i(or_en), .fastor_i(fastor),
    .strobe_i(strobe), .col_strobe_o(col_strobe), .chip_or_o(chip_or));

  function automatic logic [NCOL-1:0] get_in(int idx);
    if (idx <= 0 || idx <= cyc - HLEN) return '0;
    return hin[idx % HLEN];
  endfunction

  function automatic logic get_en(int idx);
    if (idx <= 0 || idx <= cyc - HLEN) return 1'b0;
    return hen[idx % HLEN];
  endfunction

  function automatic logic [NCOL-1:0] exp_tap();
    return get_in(cyc-DEPTH-1) & ~get_in(cyc-DEPTH-2) & {NCOL{get_en(cyc-DEPTH+1)}};
  endfunction

  task automatic check(string ph);
    logic orv, ssel, eor;
    logic [NCOL-1:0] ecs;
    orv  = |get_in(cyc-1);
    ssel = self_s ? orv : strobe;
    ecs  = gated ? ({NCOL{ssel}} & exp_tap()) : {NCOL{ssel}};
    eor  = or_en & orv;
    n_tests++;
    if (col_strobe !== ecs) begin
      n_fail++;
      $display("FAIL %s/%s col_strobe got %h exp %h", ph,
               self_s ? "R9" : (gated ? "R5" : "R6"), col_strobe, ecs);
    end
    n_tests++;
    if (chip_or !== eor) begin
      n_fail++;
      $display("FAIL %s/%s chip_or got %b exp %b", ph, or_en ? "R7" : "R8", chip_or, eor);
    end
  endtask

  // drive at negedge, check, then record what the next posedge samples
  task automatic step(string ph, logic [NCOL-1:0] f, logic en, logic g,
                      logic s, logic oe, logic st);
    @(negedge clk);
    fastor = f; stamp_en = en; gated = g; self_s = s; or_en = oe; strobe = st;
    #1 check(ph);
    @(posedge clk);
    cyc++;
    hin[cyc % HLEN] = f;
    hen[cyc % HLEN] = en;
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    stamp_en = 1; gated = 1; or_en = 1; strobe = 1;
    #1;
    n_tests++;
    if (col_strobe !== '0) begin n_fail++; $display("FAIL R1 col_strobe got %h exp 0", col_strobe); end
    n_tests++;
    if (chip_or !== 1'b0) begin n_fail++; $display("FAIL R1 chip_or got %b exp 0", chip_or); end
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: single rise on column 3, strobe held, gated
    step("R2", 16'h0008, 1, 1, 0, 1, 1);
    for (int i = 0; i < DEPTH + 6; i++) step("R2", 16'h0000, 1, 1, 0, 1, 1);
    // R3: held high, then low and high again
    for (int i = 0; i < 2*DEPTH; i++) step("R3", 16'h0101, 1, 1, 0, 1, 1);
    step("R3", 16'h0000, 1, 1, 0, 1, 1);
    for (int i = 0; i < DEPTH + 6; i++) step("R3", 16'h0101, 1, 1, 0, 1, 1);
    // toggling every cycle: a stamp on every other edge
    for (int i = 0; i < 2*DEPTH; i++) step("R3", (i % 2) ? 16'hffff : 16'h0000, 1, 1, 0, 1, 1);
    // R4: stamping off across a window
    for (int i = 0; i < 2*DEPTH; i++) step("R4", (i % 3 == 0) ? 16'h00f0 : 16'h0000, (i % 5) != 2, 1, 0, 1, 1);
    for (int i = 0; i < DEPTH + 4; i++) step("R4", 16'h0000, 0, 1, 0, 1, 1);
    // R10: lone column
    step("R10", 16'h8000, 1, 1, 0, 1, 1);
    for (int i = 0; i < DEPTH + 4; i++) step("R10", 16'h0000, 1, 1, 0, 1, 1);
    // R8 and R9 directed
    for (int i = 0; i < 8; i++) step("R8", 16'h0022, 1, 0, 0, 0, i[0]);
    for (int i = 0; i < 8; i++) step("R9", (i < 4) ? 16'h0400 : 16'h0000, 1, 0, 1, 1, 0);
    for (int i = 0; i < DEPTH + 4; i++) step("R9", 16'h0000, 1, 1, 1, 1, 1);
    // random mix (R5, R6, R7)
    for (int i = 0; i < 2500; i++) begin
      logic [NCOL-1:0] f;
      f = fastor;
      for (int c = 0; c < NCOL; c++) if ($urandom_range(0, 5) == 0) f[c] = ~f[c];
      step("RND", f, $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 5) != 0, $urandom_range(0, 2) != 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < HLEN; i++) begin hin[i] = '0; hen[i] = 1'b0; end
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule